// File: doc/BRIEF.md
# Biphasic Stimulation Pulse Sequencer

This block is the digital controller for a four-channel neural stimulator output stage that has no large series capacitors. Each stimulation cycle runs through four steps: an active cathodic interval, an inter-phase pause, a passive discharge interval and a rest gap. During the cathodic interval the block splits the stimulus current between two small series capacitor branches. It closes each branch's charge switch in turn and resets the idle branch, so that neither capacitor charges for long. During the discharge interval it drives the load discharge switch with a square wave rather than a static level.

One 4-bit amplitude DAC serves all channels. The block routes the selected channel's code to the DAC only while the cathodic interval runs. Channels with their enable set are served in round-robin order, one complete cycle each. Durations count ticks of a slow timing strobe, which is one pulse per 10 µs step in normal use. Branch alternation and the discharge waveform both advance on a fast switching strobe that stands in for the oscillator. Timing settings and codes are copied into shadow registers when a cycle starts, so edits made during a cycle never distort it.

Top module: `biphasic_seq`

## Requirements
- R1: A cycle runs in the fixed order cathodic, pause, discharge, rest. The four steps last `cath_len`, `ipd_len`, `dis_len` and `gap_len` slow strobes respectively. A length of 0 counts as 1. While any channel stays enabled the next cycle begins right after the rest gap.
- R2: The cathodic interval starts with branch A charging: `chg_a`=1, `rst_a_n`=1, `chg_b`=0, `rst_b_n`=0. Each fast strobe that arrives outside a dead time swaps the branches, so that `chg_b`=1, `rst_b_n`=1 and `rst_a_n`=0.
- R3: When a charge switch opens, no charge switch closes for `dead_len` clock cycles, with a minimum of 1. Both reset switches stay open during this dead time, and `chg_a` and `chg_b` are never high together.
- R4: Switch polarity is as follows. `chg_a` and `chg_b` close when high. `rst_a_n`, `rst_b_n` and `dump_n` close when low. `dump_n` stays high through the cathodic interval and the pause. Discharge starts with `dump_n` low and inverts it on every fast strobe, while all four branch switches are open.
- R5: After reset, while idle, for channels not being served, and during the rest gap, the branch switches are open (`chg_*`=0, `rst_*_n`=1) and `dump_n`=0.
- R6: `dac_code` carries the served channel's code during the cathodic interval and is 0 at all other times. Channel c's code is `amp_codes[4c+3:4c]`, with bit 0 as the LSB.
- R7: Changes to lengths, dead time or codes made during a cycle affect only cycles that start later.
- R8: Enabled channels are served round-robin in ascending index order, wrapping around. The first cycle after reset goes to the lowest enabled index.
- R9: Clearing a channel's enable during its cycle does not cut the cycle short. The cycle finishes, and the block then goes idle if no enable is set.
- R10: At most one channel shows any closed switch other than its static discharge switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NCH | Per-channel stimulation enable |
| amp_codes | input | NCH*CODE_W | Amplitude code per channel, channel c at bits [CODE_W*c +: CODE_W] |
| cath_len | input | DUR_W | Cathodic interval length in slow strobes |
| ipd_len | input | DUR_W | Inter-phase pause length in slow strobes |
| dis_len | input | DUR_W | Passive discharge length in slow strobes |
| gap_len | input | DUR_W | Rest gap length in slow strobes |
| dead_len | input | DEAD_W | Non-overlap time between charge switches, in clocks |
| step_tick | input | 1 | Slow timing strobe |
| hf_tick | input | 1 | Fast switching strobe |
| chg_a | output | NCH | Branch A charge switch, high closes |
| chg_b | output | NCH | Branch B charge switch, high closes |
| rst_a_n | output | NCH | Branch A reset switch, low closes |
| rst_b_n | output | NCH | Branch B reset switch, low closes |
| dump_n | output | NCH | Load discharge switch gate, low closes |
| dac_code | output | CODE_W | Code to the shared current DAC |

## Verification
The assertions assume that both strobes are synchronous to `clk` and last one cycle. They also assume that the settings are quiet whenever the shadow registers capture them at a cycle boundary. The dead-time assertion further assumes that a fast strobe never comes sooner than the dead time plus one clock. The stimulus keeps to these rules. It changes inputs only at falling clock edges and issues a fast strobe every fifth clock, which is longer than any dead time it programs. It edits settings mid-cycle only in the shadow test, and there the edit falls well away from any cycle boundary.

// File: rtl/biphasic_seq.sv
module biphasic_seq #(
  parameter int NCH    = 4,
  parameter int CODE_W = 4,
  parameter int DUR_W  = 16,
  parameter int DEAD_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        ch_en,
  input  logic [NCH*CODE_W-1:0] amp_codes,
  input  logic [DUR_W-1:0]      cath_len,
  input  logic [DUR_W-1:0]      ipd_len,
  input  logic [DUR_W-1:0]      dis_len,
  input  logic [DUR_W-1:0]      gap_len,
  input  logic [DEAD_W-1:0]     dead_len,
  input  logic                  step_tick,
  input  logic                  hf_tick,
  output logic [NCH-1:0]        chg_a,
  output logic [NCH-1:0]        chg_b,
  output logic [NCH-1:0]        rst_a_n,
  output logic [NCH-1:0]        rst_b_n,
  output logic [NCH-1:0]        dump_n,
  output logic [CODE_W-1:0]     dac_code
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [2:0] {ST_IDLE, ST_CATH, ST_IPD, ST_DIS, ST_GAP} st_t;

  st_t               st;
  logic [CH_W-1:0]   cur, nxt_ch;
  logic              any_en, start, phase_end;
  logic [DUR_W-1:0]  cnt, len_now;
  logic [DUR_W-1:0]  sh_cath, sh_ipd, sh_dis, sh_gap;
  logic [DEAD_W-1:0] sh_dead, dead_eff, dz;
  logic [CODE_W-1:0] sh_code;
  logic              br, osc, live;

  always_comb begin
    nxt_ch = cur;
    any_en = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      if (!any_en && ch_en[CH_W'((int'(cur) + k) % NCH)]) begin
        any_en = 1'b1;
        nxt_ch = CH_W'((int'(cur) + k) % NCH);
      end
    end
  end

  always_comb begin
    case (st)
      ST_CATH: len_now = sh_cath;
      ST_IPD:  len_now = sh_ipd;
      ST_DIS:  len_now = sh_dis;
      default: len_now = sh_gap;
    endcase
  end

  assign phase_end = step_tick && (({1'b0, cnt} + 1'b1) >= {1'b0, len_now});
  assign start     = any_en && (st == ST_IDLE || (st == ST_GAP && phase_end));
  assign dead_eff  = (sh_dead == '0) ? DEAD_W'(1) : sh_dead;
  assign live      = (st == ST_CATH) && (dz == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cur     <= CH_W'(NCH - 1);
      cnt     <= '0;
      sh_cath <= '0;
      sh_ipd  <= '0;
      sh_dis  <= '0;
      sh_gap  <= '0;
      sh_dead <= '0;
      sh_code <= '0;
      br      <= 1'b0;
      dz      <= '0;
      osc     <= 1'b0;
    end else if (start) begin
      st      <= ST_CATH;
      cur     <= nxt_ch;
      cnt     <= '0;
      sh_cath <= cath_len;
      sh_ipd  <= ipd_len;
      sh_dis  <= dis_len;
      sh_gap  <= gap_len;
      sh_dead <= dead_len;
      sh_code <= amp_codes[nxt_ch*CODE_W +: CODE_W];
      br      <= 1'b0;
      dz      <= '0;
    end else begin
      if (st != ST_IDLE) begin
        if (phase_end) begin
          cnt <= '0;
          case (st)
            ST_CATH: st <= ST_IPD;
            ST_IPD:  st <= ST_DIS;
            ST_DIS:  st <= ST_GAP;
            default: st <= ST_IDLE;
          endcase
        end else if (step_tick) begin
          cnt <= cnt + 1'b1;
        end
      end
      if (st == ST_CATH) begin
        if (dz != '0) dz <= dz - 1'b1;
        else if (hf_tick) begin
          br <= ~br;
          dz <= dead_eff;
        end
      end
      if (st == ST_IPD && phase_end) osc <= 1'b0;
      else if (st == ST_DIS && hf_tick) osc <= ~osc;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel        = (st != ST_IDLE) && (cur == CH_W'(c));
    assign chg_a[c]   = sel && live && !br;
    assign chg_b[c]   = sel && live && br;
    assign rst_a_n[c] = !(sel && live && br);
    assign rst_b_n[c] = !(sel && live && !br);
    assign dump_n[c]  = sel && (st == ST_CATH || st == ST_IPD || (st == ST_DIS && osc));
  end

  assign dac_code = (st == ST_CATH) ? sh_code : '0;

  AST_DEAD_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|chg_b) |-> !$past(|chg_a)); // R3
  AST_DEAD_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|chg_a) |-> !$past(|chg_b)); // R3
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg_a | chg_b | ~rst_a_n | ~rst_b_n | dump_n)); // R10
  AST_DUMP_OPEN_WHILE_CHARGING: assert property (@(posedge clk) disable iff (!rst_n)
    ((chg_a | chg_b) & ~dump_n) == '0); // R4
  AST_DAC_ONLY_WITH_DUMP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != '0) |-> (|dump_n)); // R6
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(sh_code) && $stable(sh_cath)); // R7
endmodule

// File: tb/biphasic_seq_tb.sv
module biphasic_seq_tb_top;
  localparam int NCH = 4;
  localparam int HF_N = 5;
  localparam int NV = 4;
  localparam int V_CODE [NV] = '{5, 15, 1, 9};
  localparam int V_CATH [NV] = '{10, 1, 7, 25};
  localparam int V_IPD  [NV] = '{10, 1, 0, 4};
  localparam int V_DIS  [NV] = '{37, 1, 12, 8};
  localparam int V_GAP  [NV] = '{3, 1, 2, 0};

  logic clk = 1'b0, rst_n = 1'b0, step_tick = 1'b1, hf_tick = 1'b0;
  logic [NCH-1:0] ch_en = '0;
  logic [3:0] codes [NCH];
  logic [15:0] cath_len, ipd_len, dis_len, gap_len;
  logic [2:0] dead_len;
  logic [NCH*4-1:0] amp_codes;
  logic [NCH-1:0] chg_a, chg_b, rst_a_n, rst_b_n, dump_n;
  logic [3:0] dac_code;
  int n_cmp = 0, n_bad = 0, hf_div = 0;
  bit done = 0;

  assign amp_codes = {codes[3], codes[2], codes[1], codes[0]};

  biphasic_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .amp_codes(amp_codes),
    .cath_len(cath_len), .ipd_len(ipd_len), .dis_len(dis_len), .gap_len(gap_len),
    .dead_len(dead_len), .step_tick(step_tick), .hf_tick(hf_tick),
    .chg_a(chg_a), .chg_b(chg_b), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
    .dump_n(dump_n), .dac_code(dac_code));

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      hf_div++;
      hf_tick = (hf_div % HF_N == 0);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fix(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    ch_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_rise(output bit ok);
    int t = 0;
    while (dac_code == 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    ok = (dac_code != 0);
  endtask

  task automatic measure(input int ch, input int lim, output int c, output int ip,
                         output int rest, output int tog, output int viol);
    logic prev;
    c = 0; ip = 0; rest = 0; tog = 0; viol = 0;
    while (dac_code != 0) begin
      if ($countones(chg_a | chg_b | ~rst_a_n | ~rst_b_n | dump_n) > 1) viol++;
      c++;
      @(negedge clk);
    end
    while (dump_n[ch] && ip < lim) begin
      if (dac_code != 0) viol++;
      ip++;
      @(negedge clk);
    end
    prev = dump_n[ch];
    while (dac_code == 0 && rest < lim) begin
      if (chg_a[ch] || chg_b[ch] || !rst_a_n[ch] || !rst_b_n[ch]) viol++;
      if ($countones(chg_a | chg_b | ~rst_a_n | ~rst_b_n | dump_n) > 1) viol++;
      if (dump_n[ch] != prev) tog++;
      prev = dump_n[ch];
      rest++;
      @(negedge clk);
    end
  endtask

  task automatic check_idle(input string req);
    chk(req, int'(chg_a), 0);
    chk(req, int'(chg_b), 0);
    chk(req, int'(rst_a_n), 15);
    chk(req, int'(rst_b_n), 15);
    chk(req, int'(dump_n), 0);
    chk(req, int'(dac_code), 0);
  endtask

  task automatic dead_test(input int dl, input int exp_d);
    bit ok;
    int d = 0;
    do_reset();
    dead_len = 3'(dl); cath_len = 40; ipd_len = 2; dis_len = 10; gap_len = 2;
    ch_en = 4'b0001;
    wait_rise(ok);
    chk("R2 start chg_a", int'(chg_a[0]), 1);
    chk("R2 start rst_a_n", int'(rst_a_n[0]), 1);
    chk("R2 start chg_b", int'(chg_b[0]), 0);
    chk("R2 start rst_b_n", int'(rst_b_n[0]), 0);
    while (chg_a[0] && dac_code != 0) @(negedge clk);
    chk("R3 resets open in dead time", int'(rst_a_n[0] & rst_b_n[0]), 1);
    while (!chg_a[0] && !chg_b[0] && dac_code != 0) begin
      d++;
      @(negedge clk);
    end
    chk("R3 dead time clocks", d, exp_d);
    chk("R2 swapped chg_b", int'(chg_b[0]), 1);
    chk("R2 swapped rst_a_n", int'(rst_a_n[0]), 0);
    chk("R2 swapped rst_b_n", int'(rst_b_n[0]), 1);
    ch_en = '0;
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    int c, ip, rest, tog, viol;
    for (int i = 0; i < NCH; i++) codes[i] = 4'(i + 2);
    cath_len = 4; ipd_len = 2; dis_len = 4; gap_len = 2; dead_len = 1;
    do_reset();
    check_idle("R5 reset");

    for (int v = 0; v < NV; v++) begin
      codes[0] = 4'(V_CODE[v]);
      cath_len = 16'(V_CATH[v]); ipd_len = 16'(V_IPD[v]);
      dis_len = 16'(V_DIS[v]); gap_len = 16'(V_GAP[v]);
      ch_en = 4'b0001;
      wait_rise(ok);
      chk("R6 dac code", int'(dac_code), V_CODE[v]);
      measure(0, 3000, c, ip, rest, tog, viol);
      chk("R1 cathodic length", c, fix(V_CATH[v]));
      chk("R1 pause length", ip, fix(V_IPD[v]));
      chk("R1 cycle period", c + ip + rest,
          fix(V_CATH[v]) + fix(V_IPD[v]) + fix(V_DIS[v]) + fix(V_GAP[v]));
      chk("R4 switches open after cathodic", viol, 0);
      ch_en = '0;
      repeat (fix(V_CATH[v]) + fix(V_IPD[v]) + fix(V_DIS[v]) + fix(V_GAP[v]) + 3) @(negedge clk);
      check_idle("R5 idle after vector");
    end

    dead_test(2, 2);
    dead_test(0, 1);

    do_reset();
    codes[0] = 4'd7; cath_len = 6; ipd_len = 3; dis_len = 30; gap_len = 2;
    ch_en = 4'b0001;
    wait_rise(ok);
    measure(0, 3000, c, ip, rest, tog, viol);
    chk("R4 discharge toggles seen", int'(tog >= 4), 1);
    chk("R4 branch switches open in discharge", viol, 0);
    ch_en = '0;
    repeat (60) @(negedge clk);

    do_reset();
    codes[0] = 4'd3; codes[2] = 4'd9;
    cath_len = 4; ipd_len = 2; dis_len = 4; gap_len = 2;
    ch_en = 4'b0101;
    wait_rise(ok);
    chk("R8 first channel", int'(chg_a), 1);
    chk("R8 first code", int'(dac_code), 3);
    measure(0, 3000, c, ip, rest, tog, viol);
    chk("R10 single channel", viol, 0);
    chk("R8 second channel", int'(chg_a), 4);
    chk("R8 second code", int'(dac_code), 9);
    measure(2, 3000, c, ip, rest, tog, viol);
    chk("R8 wrap channel", int'(chg_a), 1);
    chk("R10 single channel rr", viol, 0);
    ch_en = '0;
    repeat (40) @(negedge clk);

    do_reset();
    codes[0] = 4'd6; cath_len = 12; ipd_len = 3; dis_len = 10; gap_len = 3;
    ch_en = 4'b0001;
    wait_rise(ok);
    codes[0] = 4'd11; cath_len = 5;
    chk("R7 code held", int'(dac_code), 6);
    measure(0, 3000, c, ip, rest, tog, viol);
    chk("R7 old length kept", c, 12);
    chk("R7 new code next cycle", int'(dac_code), 11);
    measure(0, 3000, c, ip, rest, tog, viol);
    chk("R7 new length next cycle", c, 5);
    ch_en = '0;
    repeat (40) @(negedge clk);

    do_reset();
    codes[0] = 4'd12; cath_len = 20; ipd_len = 5; dis_len = 30; gap_len = 5;
    ch_en = 4'b0001;
    wait_rise(ok);
    repeat (3) @(negedge clk);
    ch_en = '0;
    measure(0, 300, c, ip, rest, tog, viol);
    chk("R9 cathodic completes", c + 3, 20);
    chk("R9 pause kept", ip, 5);
    chk("R9 discharge still toggles", int'(tog >= 2), 1);
    chk("R9 no new cycle", int'(rest == 300), 1);
    check_idle("R9 idle");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule